// File: doc/BRIEF.md
# Double-Buffered SPI Master with Status Register

This block is the buffering and status core of a serial peripheral interface port. It has a single mode-0 master shift engine behind it. A CPU reaches it through two register addresses. The data address is shared by both directions: a write queues a word in a transmit holding register, and a read takes the word waiting in a receive holding register. The status address holds a 16-bit word with two control bits (enable and halt-on-idle), a sticky overflow flag, and two hardware-owned occupancy flags.

The holding registers decouple the CPU from the shifter. A queued word moves into the shift register as soon as the engine is free, so software can write the next word while the current one is still on the wire. A finished word lands in the receive holding register. If software has not yet taken the previous word, the new arrival is dropped and the overflow flag records the loss. The serial clock comes from the system clock through a parameterised divider. The word width is a parameter of 8 or 16 bits.

Top module: `spi_buffered_port`

## Requirements
- R1: After reset the status word reads 0x0000, the serial clock is low and the data address reads 0.
- R2: Status word layout: bit 15 enable (read/write), bit 13 halt-on-idle (read/write), bit 6 overflow, bit 1 transmit-full, bit 0 receive-full. Every other bit reads 0, and writes to bits 1 and 0 have no effect.
- R3: A CPU write to the data address (cpuAddr=0) while enabled stores the word and sets transmit-full on that clock edge. A data write while disabled is ignored.
- R4: With the engine idle, a set transmit-full clears on the next clock edge as the word moves to the shift register. A word written while a transfer runs keeps transmit-full set until that transfer ends.
- R5: Transfers are MSB first with the serial clock idle low. mosi changes on falling edges, miso is sampled on rising edges, and there are WORD_W clock pulses each of 2*CLK_DIV system cycles.
- R6: At the end of a transfer with receive-full clear, the received word enters the receive holding register and receive-full sets.
- R7: A CPU read of the data address returns the receive holding register, zero-extended to 16 bits, and clears receive-full.
- R8: A transfer that ends while receive-full is set discards its word, keeps the unread word and sets overflow.
- R9: Overflow is cleared only by a status write with bit 6 at 0. Writing 1 there leaves it unchanged.
- R10: Clearing enable aborts any transfer, forces the serial clock low and clears both full flags. Halt-on-idle keeps its value.
- R11: With halt-on-idle set, a high idleReq freezes the serial clock and holds off any pending load. With halt-on-idle clear, idleReq has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| idleReq | input | 1 | Device idle request |
| cpuAddr | input | 1 | Register select: 0 data, 1 status |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuRdEn | input | 1 | CPU read strobe (side effects on data address) |
| cpuWrData | input | 16 | CPU write data |
| cpuRdData | output | 16 | CPU read data for the selected address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench drives a slave model on the serial pins, so data must cross in both directions in MSB-first order. A design with the wrong bit order or sampling edge would return a word that is shifted or reversed. A word written during the cycle in which the previous word loads must stay queued rather than be lost. A transfer that ends on an unread word must keep the old word and raise overflow; a design that got this wrong would overwrite the old word or leave the flag low. The bench also writes 1 to the overflow bit, disables the port in mid-transfer and holds idle with and without halt-on-idle. A faulty design would clear the flag, leave the serial clock high or the flags set, or keep shifting while halted.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int BIT_EN   = 15;
  localparam int BIT_SIDL = 13;
  localparam int BIT_OVF  = 6;
  localparam int BIT_TXF  = 1;
  localparam int BIT_RXF  = 0;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic holdLoad;   // CPU word into transmit holding register
    logic shiftLoad;  // holding register into shift register
    logic sampleIn;   // capture miso (rising serial edge)
    logic shiftStep;  // advance shift register (falling serial edge)
    logic rxCapture;  // finished word into receive holding register
    logic abort;      // module disabled
  } strobe_t;
endpackage

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl
  import spi_buf_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        idleReq,
  input  logic        cpuAddr,
  input  logic        cpuWrEn,
  input  logic        cpuRdEn,
  input  logic [15:0] cpuWrData,
  output strobe_t     strobes,
  output logic [15:0] statusWord,
  output logic        sck
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] DIV_RELOAD = CNT_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(WORD_W - 1);

  logic enBit, sidlBit, ovfBit, txFull, rxFull;
  logic busy, sckQ;
  logic [CNT_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;

  logic statWr, dataWr, dataRd, enNext, run, tick, rise, fall, done;
  logic shiftLoad, rxCapture, abort;

  always_comb begin
    statWr    = cpuWrEn && (cpuAddr == ADDR_STAT);
    dataWr    = cpuWrEn && (cpuAddr == ADDR_DATA) && enBit;
    dataRd    = cpuRdEn && (cpuAddr == ADDR_DATA);
    enNext    = statWr ? cpuWrData[BIT_EN] : enBit;
    abort     = !enNext;
    run       = enBit && enNext && !(sidlBit && idleReq);
    tick      = busy && run && (divCnt == '0);
    rise      = tick && !sckQ;
    fall      = tick && sckQ;
    done      = fall && (bitCnt == LAST_BIT);
    shiftLoad = run && !busy && txFull;
    rxCapture = done && !rxFull;
  end

  always_comb begin
    strobes.holdLoad  = dataWr;
    strobes.shiftLoad = shiftLoad;
    strobes.sampleIn  = rise;
    strobes.shiftStep = fall;
    strobes.rxCapture = rxCapture;
    strobes.abort     = abort;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      sidlBit <= 1'b0;
      ovfBit  <= 1'b0;
      txFull  <= 1'b0;
      rxFull  <= 1'b0;
      busy    <= 1'b0;
      sckQ    <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else begin
      if (statWr) begin
        enBit   <= cpuWrData[BIT_EN];
        sidlBit <= cpuWrData[BIT_SIDL];
        if (!cpuWrData[BIT_OVF]) ovfBit <= 1'b0;
      end
      if (abort) begin
        txFull <= 1'b0;
        rxFull <= 1'b0;
        busy   <= 1'b0;
        sckQ   <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
      end else begin
        if (shiftLoad) begin
          busy   <= 1'b1;
          divCnt <= DIV_RELOAD;
          bitCnt <= '0;
        end else if (busy && run) begin
          if (divCnt == '0) begin
            divCnt <= DIV_RELOAD;
            sckQ   <= ~sckQ;
            if (fall) bitCnt <= bitCnt + 1'b1;
            if (done) busy <= 1'b0;
          end else begin
            divCnt <= divCnt - 1'b1;
          end
        end
        if (dataWr)         txFull <= 1'b1;
        else if (shiftLoad) txFull <= 1'b0;
        if (rxCapture)      rxFull <= 1'b1;
        else if (dataRd)    rxFull <= 1'b0;
        if (done && rxFull) ovfBit <= 1'b1;
      end
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[BIT_EN]   = enBit;
    statusWord[BIT_SIDL] = sidlBit;
    statusWord[BIT_OVF]  = ovfBit;
    statusWord[BIT_TXF]  = txFull;
    statusWord[BIT_RXF]  = rxFull;
  end

  assign sck = sckQ;
endmodule

// File: rtl/spi_buf_datapath.sv
module spi_buf_datapath
  import spi_buf_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [15:0]       cpuWrData,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  logic [WORD_W-1:0] txHold, shiftReg, rxHold;
  logic inBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold   <= '0;
      shiftReg <= '0;
      rxHold   <= '0;
      inBit    <= 1'b0;
    end else begin
      if (strobes.holdLoad) txHold <= cpuWrData[WORD_W-1:0];
      if (strobes.abort) begin
        shiftReg <= '0;
        inBit    <= 1'b0;
      end else begin
        if (strobes.shiftLoad)      shiftReg <= txHold;
        else if (strobes.shiftStep) shiftReg <= {shiftReg[WORD_W-2:0], inBit};
        if (strobes.sampleIn)       inBit <= miso;
        if (strobes.rxCapture)      rxHold <= {shiftReg[WORD_W-2:0], inBit};
      end
    end
  end

  assign mosi   = shiftReg[WORD_W-1];
  assign rxWord = rxHold;
endmodule

// File: rtl/spi_buffered_port.sv
module spi_buffered_port
  import spi_buf_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        idleReq,
  input  logic        cpuAddr,
  input  logic        cpuWrEn,
  input  logic        cpuRdEn,
  input  logic [15:0] cpuWrData,
  output logic [15:0] cpuRdData,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  strobe_t           strobes;
  logic [15:0]       statusWord;
  logic [WORD_W-1:0] rxWord;
  logic [15:0]       rxWide;

  spi_buf_ctrl #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .idleReq(idleReq),
    .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .cpuWrData(cpuWrData), .strobes(strobes),
    .statusWord(statusWord), .sck(sck)
  );

  spi_buf_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cpuWrData(cpuWrData), .miso(miso),
    .mosi(mosi), .rxWord(rxWord)
  );

  generate
    if (WORD_W < 16) begin : g_narrow
      assign rxWide = {{(16 - WORD_W){1'b0}}, rxWord};
    end else begin : g_full
      assign rxWide = rxWord[15:0];
    end
  endgenerate

  assign cpuRdData = (cpuAddr == ADDR_STAT) ? statusWord : rxWide;
endmodule

// File: rtl/spi_buffered_port_chk.sv
module spi_buffered_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        idleReq,
  input logic        cpuAddr,
  input logic        cpuWrEn,
  input logic        cpuRdEn,
  input logic [15:0] cpuWrData,
  input logic        sck,
  input logic [15:0] statusView
);
  logic statWr;
  assign statWr = cpuWrEn && cpuAddr;

  AST_TX_WRITE_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !cpuAddr && statusView[15]) |=> statusView[1]); // R3

  AST_RX_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && !cpuAddr && !cpuWrEn && statusView[0]) |=> !statusView[0]); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusView[6] && !(statWr && !cpuWrData[6])) |=> statusView[6]); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !statusView[15] |-> (!sck && !statusView[1] && !statusView[0])); // R10

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (statusView[15] && statusView[13] && idleReq && !statWr) |=> $stable(sck)); // R11
endmodule

bind spi_buffered_port spi_buffered_port_chk u_chk (
  .clk(clk), .rstN(rstN), .idleReq(idleReq), .cpuAddr(cpuAddr),
  .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuWrData(cpuWrData),
  .sck(sck), .statusView(statusWord)
);

// File: tb/sim_spi_buffered_port.sv
`timescale 1ns/1ps
module sim_spi_buffered_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleReq = 1'b0;
  logic cpuAddr = 1'b1;
  logic cpuWrEn = 1'b0;
  logic cpuRdEn = 1'b0;
  logic [15:0] cpuWrData = '0;
  logic [15:0] cpuRdData;
  logic sck, mosi, miso;
  logic [15:0] slaveTx = '0;
  logic [15:0] slaveRx = '0;
  int errors = 0;
  int checks = 0;
  logic [15:0] rd;

  always #2 clk = ~clk;

  spi_buffered_port #(.WORD_W(8), .CLK_DIV(2)) u0 (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .cpuAddr(cpuAddr),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // mode-0 slave: sample on rising, shift on falling
  assign miso = slaveTx[15];
  always @(posedge sck) slaveRx <= {slaveRx[14:0], mosi};
  always @(negedge sck) slaveTx <= {slaveTx[14:0], 1'b0};

  task automatic check(input string tag, input logic ok, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check(tag, act === exp, act, exp);
  endtask

  task automatic cpuWrite(input logic addr, input logic [15:0] data);
    cpuAddr = addr; cpuWrData = data; cpuWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    cpuWrEn = 1'b0; cpuAddr = 1'b1;
  endtask

  task automatic readStatus(output logic [15:0] v);
    cpuAddr = 1'b1; #1; v = cpuRdData;
  endtask

  task automatic readData(output logic [15:0] v);
    cpuAddr = 1'b0; cpuRdEn = 1'b1; #1; v = cpuRdData;
    @(posedge clk); @(negedge clk);
    cpuRdEn = 1'b0; cpuAddr = 1'b1;
  endtask

  task automatic waitRxFull(input string tag);
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      readStatus(s);
      if (s[0]) return;
      @(negedge clk);
    end
    check(tag, 1'b0, 16'h0, 16'h1);
  endtask

  task automatic t_reset();
    readStatus(rd);
    checkEq("R1 status after reset", rd, 16'h0000);
    checkEq("R1 sck low after reset", {15'h0, sck}, 16'h0);
    cpuAddr = 1'b0; #1; rd = cpuRdData; cpuAddr = 1'b1;
    checkEq("R1 data reads zero", rd, 16'h0000);
  endtask

  task automatic t_disabled_write();
    cpuWrite(1'b0, 16'h00AA);
    readStatus(rd);
    checkEq("R3 data write ignored while disabled", rd, 16'h0000);
  endtask

  task automatic t_layout();
    cpuWrite(1'b1, 16'hFFFF);
    readStatus(rd);
    checkEq("R2 layout after all-ones write", rd, 16'hA000);
    cpuWrite(1'b1, 16'h8000);
    readStatus(rd);
    checkEq("R2 enable only", rd, 16'h8000);
  endtask

  task automatic t_single();
    slaveTx = 16'h3C00; slaveRx = '0;
    cpuWrite(1'b0, 16'h00A5);
    readStatus(rd);
    checkEq("R3 transmit-full set by data write", rd & 16'h0002, 16'h0002);
    @(negedge clk);
    readStatus(rd);
    checkEq("R4 transmit-full clears on load", rd & 16'h0002, 16'h0000);
    waitRxFull("R6 receive-full never set");
    checkEq("R5 slave received MSB first", slaveRx & 16'h00FF, 16'h00A5);
    checkEq("R5 sck idle low after transfer", {15'h0, sck}, 16'h0);
    readData(rd);
    checkEq("R6 R7 received word zero-extended", rd, 16'h003C);
    readStatus(rd);
    checkEq("R7 read clears receive-full", rd, 16'h8000);
  endtask

  task automatic t_stream();
    slaveTx = 16'h6BD2; slaveRx = '0;
    cpuWrite(1'b0, 16'h0081);
    cpuWrite(1'b0, 16'h0017);
    repeat (10) @(negedge clk);
    readStatus(rd);
    checkEq("R4 second word stays queued while busy", rd & 16'h0002, 16'h0002);
    waitRxFull("R6 first word");
    readData(rd);
    checkEq("R6 first streamed word", rd, 16'h006B);
    @(negedge clk);
    waitRxFull("R6 second word");
    readData(rd);
    checkEq("R6 second streamed word", rd, 16'h00D2);
    checkEq("R5 slave saw both words", slaveRx, 16'h8117);
  endtask

  task automatic t_overflow();
    slaveTx = 16'h1199; slaveRx = '0;
    cpuWrite(1'b0, 16'h0022);
    cpuWrite(1'b0, 16'h0033);
    waitRxFull("R6 overflow setup");
    repeat (60) @(negedge clk);
    readStatus(rd);
    checkEq("R8 overflow flag set, old word kept", rd, 16'h8041);
    readData(rd);
    checkEq("R8 unread word retained", rd, 16'h0011);
    cpuWrite(1'b1, 16'h8040);
    readStatus(rd);
    checkEq("R9 writing 1 to overflow keeps it", rd, 16'h8040);
    cpuWrite(1'b1, 16'h8000);
    readStatus(rd);
    checkEq("R9 writing 0 clears overflow", rd, 16'h8000);
  endtask

  task automatic t_idle();
    slaveTx = 16'h4E00; slaveRx = '0;
    cpuWrite(1'b1, 16'hA000);
    idleReq = 1'b1;
    cpuWrite(1'b0, 16'h005A);
    repeat (20) @(negedge clk);
    readStatus(rd);
    checkEq("R11 halted: load held off", rd, 16'hA002);
    checkEq("R11 halted: sck low", {15'h0, sck}, 16'h0);
    idleReq = 1'b0;
    waitRxFull("R11 resume after idle");
    readData(rd);
    checkEq("R11 word after resume", rd, 16'h004E);
    checkEq("R11 slave got word after resume", slaveRx & 16'h00FF, 16'h005A);
    slaveTx = 16'hC300; slaveRx = '0;
    cpuWrite(1'b1, 16'h8000);
    idleReq = 1'b1;
    cpuWrite(1'b0, 16'h0096);
    waitRxFull("R11 runs during idle when halt bit clear");
    readData(rd);
    checkEq("R11 idle ignored with halt bit clear", rd, 16'h00C3);
    idleReq = 1'b0;
  endtask

  task automatic t_abort();
    logic seen;
    seen = 1'b0;
    slaveTx = 16'h5500; slaveRx = '0;
    cpuWrite(1'b0, 16'h0001);
    waitRxFull("R10 setup");
    cpuWrite(1'b0, 16'h00F0);
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (sck) seen = 1'b1;
    end
    check("R10 transfer started", seen, {15'h0, seen}, 16'h1);
    cpuWrite(1'b1, 16'h2000);
    readStatus(rd);
    checkEq("R10 disable clears flags keeps halt bit", rd, 16'h2000);
    checkEq("R10 sck forced low", {15'h0, sck}, 16'h0);
    repeat (20) @(negedge clk);
    checkEq("R10 sck stays low", {15'h0, sck}, 16'h0);
    cpuWrite(1'b1, 16'h8000);
    readStatus(rd);
    checkEq("R10 re-enable clean", rd, 16'h8000);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=0x0000 expected=0x0001");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_write();
    t_layout();
    t_single();
    t_stream();
    t_overflow();
    t_idle();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule